// File: doc/BRIEF.md
# Register-Triggered Descriptor Enqueue Queue

This block is the register front end of a DMA job queue. Software programs two persistent descriptor fields, a configuration/filter base address and a configuration length. It then writes an input/output base address. That last write is the trigger: it snapshots the two persistent fields together with the written address into a descriptor and pushes the descriptor into an internal FIFO. The persistent fields keep their values, so a run of jobs that share a configuration needs only one write per job.

Each descriptor also carries a derived filter address. The length register holds the number of 64-bit configuration words minus two, so the filter data starts right after the configuration buffer, at base + (length + 2) × 8 bytes. A downstream engine drains descriptors through a valid/ready pop port. A read-only diagnostics word reports three conditions:
- a sticky overflow flag,
- a near-full level,
- a request-limit condition; once the limit is reached, further triggers are rejected.

Base addresses that are not aligned to the external memory word size raise an error pulse, and no descriptor is built from them.

Top module: `desc_enqueue_top`

## Requirements
- R1: After a synchronous active-low reset, the three writable registers and the diagnostics word read as 0, `job_valid` is 0 and `misalign_err` is 0.
- R2: Registers are at byte offsets 0x0 (configuration base), 0x4 (length minus two) and 0x8 (input/output base). Each reads back the last value written to it. Offset 0xC (diagnostics) ignores writes. Any other offset reads 0.
- R3: Writes to 0x0 and 0x4 never enqueue. Their values persist across enqueues, so repeated writes to 0x8 alone produce descriptors that reuse the last base and length.
- R4: An accepted write to 0x8 pushes the descriptor {configuration base, length field, written data, filter address} into the FIFO. The descriptor is visible on the job outputs from the cycle after the write, and descriptors leave in push order.
- R5: The filter address equals the configuration base + (length field + 2) × 8, modulo 2^32.
- R6: Diagnostics bit 0 is set when an accepted trigger finds the FIFO full and no pop happens in the same cycle. That descriptor is discarded. The bit clears only on reset.
- R7: Diagnostics bit 1 is 1 whenever the FIFO holds at least DEPTH−1 entries (default DEPTH = 8).
- R8: Diagnostics bit 2 is 1 once REQ_LIMIT triggers (default 24) have been accepted. After that, triggers are discarded and do not set bit 0. Bits 31:3 read 0.
- R9: A trigger is not accepted, and not counted, if the written 0x8 value or the stored configuration base has any of its low log2(WORD_BYTES) bits set (default WORD_BYTES = 8). `misalign_err` is 1 in the cycle after any such misaligned write to 0x0 or 0x8.
- R10: A descriptor is popped when `job_valid` and `job_ready` are both 1. A trigger that coincides with a pop while the FIFO is full is stored and does not set bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data (combinational from `reg_addr`) |
| misalign_err | output | 1 | One-cycle pulse after a misaligned base-address write |
| job_valid | output | 1 | A descriptor is available |
| job_ready | input | 1 | Consumer accepts the presented descriptor |
| job_cfg_base | output | 32 | Configuration base address of the head descriptor |
| job_cfg_len_m2 | output | 32 | Length field (configuration words minus two) |
| job_io_base | output | 32 | Input/output base address |
| job_filter_addr | output | 32 | Derived filter address |

## Verification
The bench sweeps lengths and bases that include a length of 0xFFFFFFFE and a base near the top of the address space. A design that used the raw length, forgot the ×8 scaling or widened the sum would produce a wrong filter address on those cases. It fills the FIFO one entry at a time and compares the near-full bit at every level. It then attempts a push while full, which shows whether the extra descriptor is discarded or overwrites an entry and whether the overflow flag stays set, and a push while full that coincides with a pop, where a design that ignored the pop would drop the job or raise a false overflow. It also drives misaligned addresses and runs the request count up to its limit, where a design that counted rejected triggers, or let a trigger through after the limit, would be caught by the order and number of descriptors that come out.

// File: rtl/desc_pkg.sv
// Package: shared widths and the descriptor record for the enqueue queue.
// Assumes a 32-bit register bus and 64-bit configuration words.
package desc_pkg;
    localparam int unsigned DATA_W         = 32;
    localparam int unsigned CFG_WORD_BYTES = 8;
    localparam int unsigned LEN_BIAS       = 2;

    typedef struct packed {
        logic [DATA_W-1:0] cfg_base;
        logic [DATA_W-1:0] cfg_len_m2;
        logic [DATA_W-1:0] io_base;
        logic [DATA_W-1:0] filter_addr;
    } desc_t;
endpackage

// File: rtl/desc_regfile.sv
// Module: desc_regfile
// Holds the three writable descriptor registers and decodes the trigger
// write. Builds the candidate descriptor, derived filter address included,
// from the stored fields and the write data. Also flags misaligned
// base-address writes.
// Assumes: byte offsets 0x0/0x4/0x8/0xC, and WORD_BYTES is a power of two.
module desc_regfile
    import desc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned WORD_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        diag,
    output logic [DATA_W-1:0] rd_data,
    output logic              trig,
    output desc_t             cand,
    output logic              misalign_err
);
    localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_LEN  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_IO   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFF_DIAG = ADDR_W'(12);
    localparam logic [DATA_W-1:0] ALIGN_MASK = DATA_W'(WORD_BYTES - 1);
    localparam logic [DATA_W-1:0] BIAS       = DATA_W'(LEN_BIAS);
    localparam logic [DATA_W-1:0] WBYTES     = DATA_W'(CFG_WORD_BYTES);

    logic [DATA_W-1:0] cfg_q, len_q, io_q;
    logic sel_cfg, sel_len, sel_io, data_misaligned, cfg_misaligned;

    assign sel_cfg = (addr == OFF_CFG);
    assign sel_len = (addr == OFF_LEN);
    assign sel_io  = (addr == OFF_IO);
    assign data_misaligned = |(wr_data & ALIGN_MASK);
    assign cfg_misaligned  = |(cfg_q & ALIGN_MASK);

    // Purpose: capture register writes; the diagnostics offset is read-only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            len_q <= '0;
            io_q  <= '0;
        end else if (wr_en) begin
            if (sel_cfg) cfg_q <= wr_data;
            if (sel_len) len_q <= wr_data;
            if (sel_io)  io_q  <= wr_data;
        end
    end

    // Purpose: pulse the error output one cycle after a misaligned base write.
    always_ff @(posedge clk) begin
        if (!rst_n) misalign_err <= 1'b0;
        else        misalign_err <= wr_en && (sel_cfg || sel_io) && data_misaligned;
    end

    // Purpose: a trigger is an aligned 0x8 write while the stored base is aligned.
    assign trig = wr_en && sel_io && !data_misaligned && !cfg_misaligned;

    // Purpose: assemble the descriptor that a trigger would push.
    always_comb begin
        cand.cfg_base    = cfg_q;
        cand.cfg_len_m2  = len_q;
        cand.io_base     = wr_data;
        cand.filter_addr = cfg_q + (len_q + BIAS) * WBYTES;
    end

    // Purpose: register read mux; unmapped offsets return zero.
    always_comb begin
        if (sel_cfg)              rd_data = cfg_q;
        else if (sel_len)         rd_data = len_q;
        else if (sel_io)          rd_data = io_q;
        else if (addr == OFF_DIAG) rd_data = {{(DATA_W-3){1'b0}}, diag};
        else                      rd_data = '0;
    end

    // R3: the configuration base changes only through a write to its own offset
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_cfg) |=> $stable(cfg_q));
    assert_len_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel_len) |=> $stable(len_q));
    // R9: a misaligned base write is reported on the next cycle
    assert_misalign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_io && data_misaligned) |=> misalign_err);
endmodule

// File: rtl/desc_admit.sv
// Module: desc_admit
// Decides whether a trigger becomes a push. It counts accepted requests up
// to REQ_LIMIT, rejects triggers once the limit is reached, and raises a
// sticky overflow flag when an accepted trigger meets a full FIFO with no
// pop in the same cycle.
// Assumes: REQ_LIMIT >= 1.
module desc_admit #(
    parameter int unsigned REQ_LIMIT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic full,
    input  logic pop_fire,
    output logic push_ok,
    output logic overflow,
    output logic limit_hit
);
    localparam int unsigned REQ_W = $clog2(REQ_LIMIT + 1);

    logic [REQ_W-1:0] req_q;
    logic accept;

    assign limit_hit = (req_q == REQ_W'(REQ_LIMIT));
    assign accept    = trig && !limit_hit;
    assign push_ok   = accept && (!full || pop_fire);

    // Purpose: count accepted requests, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      req_q <= '0;
        else if (accept) req_q <= req_q + REQ_W'(1);
    end

    // Purpose: sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              overflow <= 1'b0;
        else if (accept && full && !pop_fire)    overflow <= 1'b1;
    end

    // R6: overflow never falls outside reset
    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R8: the limit condition persists and blocks every push
    assert_limit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |=> limit_hit);
    assert_limit_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |-> !push_ok);
    // R10: a push into a full FIFO alongside a pop raises no overflow
    assert_full_pop_no_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!overflow && trig && full && pop_fire) |=> !overflow);
endmodule

// File: rtl/desc_fifo.sv
// Module: desc_fifo
// Circular descriptor FIFO with valid/ready pop and occupancy flags.
// Assumes: the caller raises push only when there is room or a pop
// happens in the same cycle.
module desc_fifo
    import desc_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  desc_t push_data,
    input  logic  pop_ready,
    output logic  pop_valid,
    output logic  pop_fire,
    output desc_t pop_data,
    output logic  full,
    output logic  almost_full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    desc_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] occ;

    assign pop_valid   = (occ != '0);
    assign pop_fire    = pop_valid && pop_ready;
    assign full        = (occ == CNT_W'(DEPTH));
    assign almost_full = (occ >= CNT_W'(DEPTH - 1));
    assign pop_data    = mem[rd_ptr];

    // Purpose: store a pushed descriptor at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Purpose: advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push)     wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_fire) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            if (push && !pop_fire)      occ <= occ + CNT_W'(1);
            else if (!push && pop_fire) occ <= occ - CNT_W'(1);
        end
    end

    // R6: occupancy never exceeds the depth
    assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    // R6: a push into a full FIFO only happens together with a pop
    assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop_fire));
    // R10: full with no pop stays full
    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_fire) |=> full);
endmodule

// File: rtl/desc_enqueue_top.sv
// Module: desc_enqueue_top
// Register front end that turns writes to the input/output base register
// into queued DMA descriptors and presents them on a valid/ready port.
// Assumes: single clock, synchronous active-low reset, 32-bit data.
module desc_enqueue_top
    import desc_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned REQ_LIMIT  = 24,
    parameter int unsigned WORD_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        misalign_err,
    output logic        job_valid,
    input  logic        job_ready,
    output logic [31:0] job_cfg_base,
    output logic [31:0] job_cfg_len_m2,
    output logic [31:0] job_io_base,
    output logic [31:0] job_filter_addr
);
    desc_t cand, head;
    logic  trig, push_ok, pop_fire, full, almost_full, overflow, limit_hit;

    desc_regfile #(.ADDR_W(4), .WORD_BYTES(WORD_BYTES)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
        .wr_data(reg_wr_data), .diag({limit_hit, almost_full, overflow}),
        .rd_data(reg_rd_data), .trig(trig), .cand(cand),
        .misalign_err(misalign_err)
    );

    desc_admit #(.REQ_LIMIT(REQ_LIMIT)) admit_i (
        .clk(clk), .rst_n(rst_n), .trig(trig), .full(full),
        .pop_fire(pop_fire), .push_ok(push_ok), .overflow(overflow),
        .limit_hit(limit_hit)
    );

    desc_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push_ok), .push_data(cand),
        .pop_ready(job_ready), .pop_valid(job_valid), .pop_fire(pop_fire),
        .pop_data(head), .full(full), .almost_full(almost_full)
    );

    // Purpose: expose the head descriptor fields.
    assign job_cfg_base    = head.cfg_base;
    assign job_cfg_len_m2  = head.cfg_len_m2;
    assign job_io_base     = head.io_base;
    assign job_filter_addr = head.filter_addr;

    // R4: an accepted push is visible to the consumer on the next cycle
    assert_push_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> job_valid);
endmodule

// File: tb/desc_enqueue_top_tb_top.sv
module desc_enqueue_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int LIMIT      = 24;
    localparam int WB         = 8;

    typedef struct packed {
        logic [31:0] cfg, len, io, flt;
    } exp_t;

    logic        clk = 0, rst_n = 0, reg_wr_en = 0, job_ready = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wr_data = 0;
    logic [31:0] reg_rd_data, job_cfg_base, job_cfg_len_m2, job_io_base, job_filter_addr;
    logic        misalign_err, job_valid;

    int checks = 0, errors = 0;
    exp_t q[$];
    logic [31:0] m_cfg, m_len, m_io;
    int  m_cnt;
    bit  m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_enqueue_top #(.DEPTH(DEPTH), .REQ_LIMIT(LIMIT), .WORD_BYTES(WB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .misalign_err(misalign_err), .job_valid(job_valid), .job_ready(job_ready),
        .job_cfg_base(job_cfg_base), .job_cfg_len_m2(job_cfg_len_m2),
        .job_io_base(job_io_base), .job_filter_addr(job_filter_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] filt(input logic [31:0] b, input logic [31:0] l);
        return b + (l + 32'd2) * 32'd8;
    endfunction

    function automatic logic [31:0] exp_diag();
        return {29'd0, m_cnt >= LIMIT, q.size() >= DEPTH - 1, m_ovf};
    endfunction

    task automatic model_reset();
        q.delete(); m_cfg = 0; m_len = 0; m_io = 0; m_cnt = 0; m_ovf = 0;
    endtask

    // Compare the job port with the model head (called away from the edge).
    task automatic chk_head(input string req);
        check(req, "job_valid", {31'd0, job_valid}, {31'd0, q.size() > 0});
        if (q.size() > 0) begin
            check(req, "cfg_base", job_cfg_base, q[0].cfg);
            check(req, "len_m2", job_cfg_len_m2, q[0].len);
            check(req, "io_base", job_io_base, q[0].io);
            check(req, "filter", job_filter_addr, q[0].flt);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rd_data;
    endtask

    task automatic chk_diag(input string req);
        logic [31:0] d;
        rd(4'hC, d);
        check(req, "diagnostics", d, exp_diag());
    endtask

    // Register write, optionally with a simultaneous pop; updates the model.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit pop_too);
        bit trig, err, popped;
        @(negedge clk);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1; job_ready = pop_too;
        err = (a == 4'h0 || a == 4'h8) && ((d % WB) != 0);
        trig = (a == 4'h8) && ((d % WB) == 0) && ((m_cfg % WB) == 0);
        popped = pop_too && q.size() > 0;
        if (trig && m_cnt < LIMIT) begin
            m_cnt++;
            if (popped) void'(q.pop_front());
            if (q.size() < DEPTH) q.push_back('{m_cfg, m_len, d, filt(m_cfg, m_len)});
            else m_ovf = 1;
        end else if (popped) void'(q.pop_front());
        if (a == 4'h0) m_cfg = d;
        if (a == 4'h4) m_len = d;
        if (a == 4'h8) m_io = d;
        @(negedge clk);
        reg_wr_en = 0; job_ready = 0;
        check("R9", "misalign_err", {31'd0, misalign_err}, {31'd0, err});
    endtask

    task automatic pop_one(input string req);
        @(negedge clk);
        chk_head(req);
        job_ready = 1;
        if (q.size() > 0) void'(q.pop_front());
        @(negedge clk);
        job_ready = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        model_reset();
        do_reset();
        // R1: reset state
        @(negedge clk);
        rd(4'h0, d); check("R1", "cfg reset", d, 0);
        rd(4'h4, d); check("R1", "len reset", d, 0);
        rd(4'h8, d); check("R1", "io reset", d, 0);
        chk_diag("R1");
        check("R1", "job_valid reset", {31'd0, job_valid}, 0);
        check("R1", "misalign reset", {31'd0, misalign_err}, 0);

        // R2: readback, read-only diagnostics, unmapped offset
        wr(4'h4, 32'h0000_0033, 0); rd(4'h4, d); check("R2", "len readback", d, 32'h33);
        wr(4'hC, 32'hFFFF_FFFF, 0); chk_diag("R2");
        wr(4'h2, 32'h1234_5678, 0); rd(4'h2, d); check("R2", "unmapped read", d, 0);
        check("R3", "no enqueue from 0x4 write", {31'd0, job_valid}, 0);

        // R4/R5: sweep of lengths and bases, including wrap corners
        for (int i = 0; i < 8; i++) begin
            logic [31:0] b, l;
            b = (i == 7) ? 32'hFFFF_FFF0 : 32'h1000 + i * 32'h200;
            l = (i == 6) ? 32'hFFFF_FFFE : i;
            wr(4'h0, b, 0);
            wr(4'h4, l, 0);
            check("R3", "no enqueue from cfg writes", {31'd0, job_valid}, 0);
            wr(4'h8, 32'h8000_0000 + i * 32'h100, 0);
            rd(4'h0, d); check("R2", "cfg readback", d, b);
            chk_head("R4 R5 filter sweep");
            pop_one("R4 R5");
            chk_head("R10 empty after pop");
        end

        // R3: fields persist, repeated 0x8 writes reuse them
        wr(4'h0, 32'h0002_0000, 0); wr(4'h4, 32'd10, 0);
        for (int i = 0; i < 3; i++) wr(4'h8, 32'h0040_0000 + i * 32'h40, 0);
        rd(4'h8, d); check("R2", "io readback", d, 32'h0040_0080);
        chk_diag("R7 three entries");
        for (int i = 0; i < 3; i++) pop_one("R3 reuse order");

        // R7/R6: fill level by level, then overflow
        wr(4'h4, 32'd1, 0);
        for (int i = 0; i < DEPTH; i++) begin
            wr(4'h8, 32'h0100_0000 + i * 32'h8, 0);
            chk_diag("R7 fill level");
        end
        wr(4'h8, 32'h0F00_0000, 0);
        chk_diag("R6 overflow on full");
        chk_head("R6 head unchanged");
        // R10: push while full together with a pop
        wr(4'h8, 32'h0200_0000, 1);
        chk_diag("R10 no new overflow");
        for (int i = 0; i < DEPTH; i++) begin
            pop_one("R6 R10 drain order");
            chk_diag("R7 drain level");
        end

        // R9: misaligned addresses neither enqueue nor count
        wr(4'h0, 32'h0000_0004, 0);
        wr(4'h8, 32'h0000_0100, 0);
        check("R9", "no enqueue misaligned cfg", {31'd0, job_valid}, 0);
        wr(4'h0, 32'h0000_0800, 0);
        wr(4'h8, 32'h0000_0104, 0);
        check("R9", "no enqueue misaligned io", {31'd0, job_valid}, 0);
        rd(4'h8, d); check("R2", "misaligned io stored", d, 32'h104);

        // R8: run to the limit, then a rejected trigger
        while (m_cnt < LIMIT) wr(4'h8, 32'h0300_0000 + m_cnt * 32'h10, 0);
        chk_diag("R8 limit reached");
        wr(4'h8, 32'h0400_0000, 0);
        chk_diag("R8 rejected, no overflow change");
        while (q.size() > 0) pop_one("R8 drain");
        chk_head("R8 nothing extra queued");

        // R1/R6: reset clears sticky and limit flags
        do_reset();
        @(negedge clk);
        chk_diag("R1 R6 cleared by reset");
        wr(4'h8, 32'h0000_0040, 0);
        chk_head("R8 counter cleared by reset");
        pop_one("R4 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule